// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the configuration store of an interrupt distributor built for a single processor. It keeps, for every interrupt up to a parameterised count (64 by default), an enable bit, a pending bit, an eight-bit priority, a one-bit target and a trigger type. It also keeps one global distributor switch. Software reaches this state through a byte-addressed register window. A selector block downstream reads the state straight from the exported vectors and picks the next interrupt to signal.

Each access covers one, two or four bytes starting at any address. The bytes of an access are handled as separate byte operations in ascending address order, all in the same clock cycle. Writes take effect at the clock edge. Read data is combinational from the current state. Enable and pending each have two byte views: one where a written 1 sets the bit and one where a written 1 clears it. Both views read back the current bits. Some behaviour is fixed for the lowest interrupt numbers. An access to a byte that maps to nothing, or to an interrupt beyond the implemented count, reads as zero, has no effect and sets a sticky error flag.

Top module: `dist_regfile`

## Requirements
- R1: After reset the distributor switch is off and error is 0. IDs 0 to 15 are enabled and edge-triggered. All other IDs are disabled and level-triggered. No ID is pending.
- R2: Byte offset 0x000 bit 0 is the distributor switch and reads back. Every other bit of offsets 0x000 to 0x003 reads 0 and ignores writes.
- R3: Byte 0x004 reads NIRQ/32-1 in bits 4:0, with the processor count minus one (0 here) in bits 7:5. Bytes 0x005 to 0x007 read 0. Offsets 0x080 to 0x0FF read 0, ignore writes and do not set the error flag.
- R4: Set-enable is at 0x100 and clear-enable at 0x180. Byte n covers IDs 8n to 8n+7, with bit i for ID 8n+i. Writing 1 sets or clears that ID's enable, and writing 0 leaves it unchanged. Both views read the current enables.
- R5: IDs 0 to 15 cannot be disabled. A clear-enable write to them is ignored, and a set-enable write to them leaves all 16 enabled.
- R6: Set-pending is at 0x200 and clear-pending at 0x280, with the same layout as R4. Both views read the current pending bits. A 1 on pend_set_i[id] sets that ID's pending bit at the next edge.
- R7: Bytes 0x300 onward return active_i, with the same layout as R4. Writes there change nothing and do not set the error flag.
- R8: The priority of ID n is the byte at 0x400+n. It reads back and appears on prio_o[8n+7:8n].
- R9: The target of ID n is the byte at 0x800+n, and bit 0 is stored for n at 32 or above. For n below 29 a write is forced to 0, so the byte reads 0. For n from 29 to 31 the byte reads 0x01.
- R10: Trigger configuration starts at 0xC00, with byte m covering IDs 4m to 4m+3. For ID 4m+j, bit 2j+1 = 1 means edge and 0 means level. Even bits read 0. A write for an ID below 32 always makes it edge-triggered.
- R11: A byte is out of range if it is unmapped (0x008 to 0x07F, 0x380 to 0x3FF, 0xF00 and up) or maps to an ID of NIRQ or above. Such a byte reads 0, its write is dropped, and any access to it sets err_o. err_o stays set until reset.
- R12: size 0, 1 and 2 access 1, 2 and 4 bytes at addr, addr+1 and so on, processed in ascending order in one cycle. Byte k uses wdata[8k+7:8k] and rdata[8k+7:8k]. rdata lanes beyond the size read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe, used only to flag out-of-range reads |
| addr | input | 12 | Byte address of the first lane |
| size | input | 2 | 0 = byte, 1 = half, 2 = word |
| wdata | input | 32 | Write data, lane k is the byte at addr+k |
| rdata | output | 32 | Combinational read data |
| active_i | input | NIRQ | Active flags from the selector |
| pend_set_i | input | NIRQ | Hardware pending-set pulses |
| dist_en_o | output | 1 | Global distributor switch |
| enable_o | output | NIRQ | Per-ID enable |
| pending_o | output | NIRQ | Per-ID pending |
| edge_o | output | NIRQ | Per-ID trigger type, 1 = edge |
| prio_o | output | 8*NIRQ | Per-ID priority bytes |
| err_o | output | 1 | Sticky out-of-range access flag |

## Verification
The bench targets the forced behaviour of the low IDs. A design that let a clear-enable write reach IDs 0 to 15, or left a configuration write below 32 level-triggered, would show a changed enable_o or edge_o after such writes. Target reads for IDs 28 to 31 are checked byte by byte, so a design that misses the 29/31 boundary returns the wrong byte. Multi-byte accesses are checked with misaligned halfword priority writes and partial-width reads, which expose lane swaps and stale upper lanes. The error flag is checked across the NIRQ boundary, and after each error that no state moved. A design that wraps an out-of-range ID onto a real one would corrupt enable_o.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;
    localparam int CPU_COUNT = 1;
    localparam int LANES     = 4;

    typedef logic [11:0] off_t;

    typedef enum logic [3:0] {
        RG_RAZ,
        RG_CTRL,
        RG_TYPE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_ACT,
        RG_PRIO,
        RG_TGT,
        RG_CFG,
        RG_BAD
    } region_e;
endpackage

// File: rtl/dist_lane_decode.sv
module dist_lane_decode
    import dist_regs_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int IW = $clog2(NIRQ)
) (
    input  off_t          off,
    output region_e       region,
    output logic [IW-1:0] base,
    output logic          first
);
    logic [13:0] idx;
    region_e     raw;

    always_comb begin
        idx = '0;
        raw = RG_BAD;
        if (off < 12'h100) begin
            if (off < 12'h004)      raw = RG_CTRL;
            else if (off < 12'h008) raw = RG_TYPE;
            else if (off >= 12'h080) raw = RG_RAZ;
        end else if (off < 12'h180) begin
            raw = RG_SETEN; idx = 14'(off - 12'h100) << 3;
        end else if (off < 12'h200) begin
            raw = RG_CLREN; idx = 14'(off - 12'h180) << 3;
        end else if (off < 12'h280) begin
            raw = RG_SETPD; idx = 14'(off - 12'h200) << 3;
        end else if (off < 12'h300) begin
            raw = RG_CLRPD; idx = 14'(off - 12'h280) << 3;
        end else if (off < 12'h380) begin
            raw = RG_ACT;   idx = 14'(off - 12'h300) << 3;
        end else if (off < 12'h400) begin
            raw = RG_BAD;
        end else if (off < 12'h800) begin
            raw = RG_PRIO;  idx = 14'(off - 12'h400);
        end else if (off < 12'hC00) begin
            raw = RG_TGT;   idx = 14'(off - 12'h800);
        end else if (off < 12'hF00) begin
            raw = RG_CFG;   idx = 14'(off - 12'hC00) << 2;
        end
    end

    always_comb begin
        region = raw;
        if (idx >= 14'(NIRQ)) region = RG_BAD;
        base  = idx[IW-1:0];
        first = (off[1:0] == 2'b00);
    end
endmodule

// File: rtl/dist_read_lane.sv
module dist_read_lane
    import dist_regs_pkg::*;
#(
    parameter int NIRQ = 64,
    localparam int IW = $clog2(NIRQ)
) (
    input  region_e         region,
    input  logic [IW-1:0]   base,
    input  logic            first,
    input  logic            dist_en,
    input  logic [NIRQ-1:0] en,
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] act,
    input  logic [NIRQ-1:0] trig,
    input  logic [NIRQ-1:0] tgt,
    input  logic [8*NIRQ-1:0] prio,
    output logic [7:0]      rbyte
);
    localparam logic [7:0] TYPE_BYTE = 8'(NIRQ / 32 - 1) | 8'((CPU_COUNT - 1) << 5);

    always_comb begin
        rbyte = 8'h00;
        unique case (region)
            RG_CTRL: rbyte = {7'b0, first & dist_en};
            RG_TYPE: rbyte = first ? TYPE_BYTE : 8'h00;
            RG_SETEN, RG_CLREN:
                for (int i = 0; i < 8; i++) rbyte[i] = en[base + IW'(i)];
            RG_SETPD, RG_CLRPD:
                for (int i = 0; i < 8; i++) rbyte[i] = pend[base + IW'(i)];
            RG_ACT:
                for (int i = 0; i < 8; i++) rbyte[i] = act[base + IW'(i)];
            RG_PRIO: rbyte = prio[{base, 3'b000} +: 8];
            RG_TGT:
                if (base >= IW'(29) && base < IW'(32)) rbyte = 8'h01;
                else rbyte = {7'b0, tgt[base]};
            RG_CFG:
                for (int i = 0; i < 4; i++) rbyte[2*i+1] = trig[base + IW'(i)];
            default: rbyte = 8'h00;
        endcase
    end
endmodule

// File: rtl/dist_regfile.sv
module dist_regfile
    import dist_regs_pkg::*;
#(
    parameter int NIRQ = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NIRQ-1:0]   active_i,
    input  logic [NIRQ-1:0]   pend_set_i,
    output logic              dist_en_o,
    output logic [NIRQ-1:0]   enable_o,
    output logic [NIRQ-1:0]   pending_o,
    output logic [NIRQ-1:0]   edge_o,
    output logic [8*NIRQ-1:0] prio_o,
    output logic              err_o
);
    localparam int IW = $clog2(NIRQ);
    localparam logic [NIRQ-1:0] LOW16 = {{(NIRQ-16){1'b0}}, 16'hFFFF};

    logic              den_q, den_n, err_q, bad;
    logic [NIRQ-1:0]   en_q, en_n, pd_q, pd_n, trig_q, trig_n, tgt_q, tgt_n;
    logic [8*NIRQ-1:0] prio_q, prio_n;
    logic [LANES-1:0]  lane_on;
    region_e           rg    [LANES];
    logic [IW-1:0]     base  [LANES];
    logic              first [LANES];
    logic [7:0]        rbyte [LANES];

    always_comb begin
        for (int k = 0; k < LANES; k++)
            lane_on[k] = (size == 2'd0) ? (k == 0) : (size == 2'd1) ? (k < 2) : 1'b1;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dist_lane_decode #(.NIRQ(NIRQ)) u_dec (
            .off(addr + 12'(k)), .region(rg[k]), .base(base[k]), .first(first[k])
        );
        dist_read_lane #(.NIRQ(NIRQ)) u_rd (
            .region(rg[k]), .base(base[k]), .first(first[k]), .dist_en(den_q),
            .en(en_q), .pend(pd_q), .act(active_i), .trig(trig_q), .tgt(tgt_q),
            .prio(prio_q), .rbyte(rbyte[k])
        );
        assign rdata[8*k +: 8] = lane_on[k] ? rbyte[k] : 8'h00;
    end

    // Byte operations applied in ascending lane order
    always_comb begin
        logic [7:0] b;
        den_n  = den_q;  en_n = en_q;  pd_n = pd_q;
        trig_n = trig_q; tgt_n = tgt_q; prio_n = prio_q;
        bad    = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            b = wdata[8*k +: 8];
            if (lane_on[k] && (wr_en || rd_en) && rg[k] == RG_BAD) bad = 1'b1;
            if (lane_on[k] && wr_en) begin
                unique case (rg[k])
                    RG_CTRL: if (first[k]) den_n = b[0];
                    RG_SETEN: begin
                        if (base[k] < IW'(16)) b = 8'hFF;
                        for (int i = 0; i < 8; i++)
                            if (b[i]) en_n[base[k] + IW'(i)] = 1'b1;
                    end
                    RG_CLREN:
                        if (base[k] >= IW'(16))
                            for (int i = 0; i < 8; i++)
                                if (b[i]) en_n[base[k] + IW'(i)] = 1'b0;
                    RG_SETPD:
                        for (int i = 0; i < 8; i++)
                            if (b[i]) pd_n[base[k] + IW'(i)] = 1'b1;
                    RG_CLRPD:
                        for (int i = 0; i < 8; i++)
                            if (b[i]) pd_n[base[k] + IW'(i)] = 1'b0;
                    RG_PRIO: prio_n[{base[k], 3'b000} +: 8] = b;
                    RG_TGT:
                        if (base[k] < IW'(29))      tgt_n[base[k]] = 1'b0;
                        else if (base[k] < IW'(32)) tgt_n[base[k]] = 1'b1;
                        else                        tgt_n[base[k]] = b[0];
                    RG_CFG: begin
                        if (base[k] < IW'(32)) b = b | 8'hAA;
                        for (int i = 0; i < 4; i++)
                            trig_n[base[k] + IW'(i)] = b[2*i+1];
                    end
                    default: ;
                endcase
            end
        end
        pd_n = pd_n | pend_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q  <= 1'b0;
            en_q   <= LOW16;
            pd_q   <= '0;
            trig_q <= LOW16;
            tgt_q  <= '0;
            prio_q <= '0;
            err_q  <= 1'b0;
        end else begin
            den_q  <= den_n;
            en_q   <= en_n;
            pd_q   <= pd_n;
            trig_q <= trig_n;
            tgt_q  <= tgt_n;
            prio_q <= prio_n;
            err_q  <= err_q | bad;
        end
    end

    assign dist_en_o = den_q;
    assign enable_o  = en_q;
    assign pending_o = pd_q;
    assign edge_o    = trig_q;
    assign prio_o    = prio_q;
    assign err_o     = err_q;
endmodule

// File: rtl/dist_regfile_chk.sv
module dist_regfile_chk #(
    parameter int NIRQ = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            dist_en_o,
    input logic [NIRQ-1:0] enable_o,
    input logic [NIRQ-1:0] pending_o,
    input logic [NIRQ-1:0] edge_o,
    input logic            err_o
);
    assert_low_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o[15:0] == 16'hFFFF);

    assert_low_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o[15:0] == 16'hFFFF);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_switch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dist_en_o));

    assert_pend_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(pending_o) & ~pending_o) == '0));
endmodule

bind dist_regfile dist_regfile_chk #(.NIRQ(NIRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dist_en_o(dist_en_o),
    .enable_o(enable_o), .pending_o(pending_o), .edge_o(edge_o), .err_o(err_o)
);

// File: tb/sim_dist_regfile.sv
module sim_dist_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [1:0]        size = '0;
    logic [31:0]       wdata = '0, rdata;
    logic [NIRQ-1:0]   active_i = '0, pend_set_i = '0;
    logic              dist_en_o, err_o;
    logic [NIRQ-1:0]   enable_o, pending_o, edge_o;
    logic [8*NIRQ-1:0] prio_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dist_regfile #(.NIRQ(NIRQ)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .active_i(active_i),
        .pend_set_i(pend_set_i), .dist_en_o(dist_en_o), .enable_o(enable_o),
        .pending_o(pending_o), .edge_o(edge_o), .prio_o(prio_o), .err_o(err_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 switch", 64'(dist_en_o), 64'd0);
        check("R1 enable", enable_o, 64'h0000_0000_0000_FFFF);
        check("R1 edge", edge_o, 64'h0000_0000_0000_FFFF);
        check("R1 pending", pending_o, 64'd0);
        check("R1 err", 64'(err_o), 64'd0);
        rd(12'h000, 2'd2, d);
        check("R1 ctrl read", 64'(d), 64'd0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(12'h000, 2'd2, 32'hFFFF_FFFF);
        check("R2 switch on", 64'(dist_en_o), 64'd1);
        rd(12'h000, 2'd2, d);
        check("R2 ctrl readback", 64'(d), 64'h1);
        wr(12'h000, 2'd0, 32'h0);
        check("R2 switch off", 64'(dist_en_o), 64'd0);
    endtask

    task automatic t_type();
        logic [31:0] d;
        rd(12'h004, 2'd2, d);
        check("R3 type", 64'(d), 64'h1);
        wr(12'h080, 2'd2, 32'hFFFF_FFFF);
        rd(12'h080, 2'd2, d);
        check("R3 raz", 64'(d), 64'd0);
        check("R3 no err", 64'(err_o), 64'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(12'h104, 2'd2, 32'h0000_00A5);
        check("R4 set-enable", enable_o, 64'h0000_00A5_0000_FFFF);
        rd(12'h184, 2'd2, d);
        check("R4 clear view read", 64'(d), 64'hA5);
        rd(12'h104, 2'd2, d);
        check("R4 set view read", 64'(d), 64'hA5);
        wr(12'h184, 2'd0, 32'h05);
        check("R4 clear-enable", enable_o, 64'h0000_00A0_0000_FFFF);
        wr(12'h102, 2'd0, 32'h0F);
        wr(12'h180, 2'd2, 32'hFFFF_FFFF);
        check("R5 low ids kept", enable_o, 64'h0000_00A0_0000_FFFF);
        wr(12'h100, 2'd1, 32'h0);
        rd(12'h100, 2'd2, d);
        check("R5 low ids read", 64'(d), 64'h0000_FFFF);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(12'h204, 2'd1, 32'h8001);
        check("R6 set-pending", pending_o, 64'h0000_8001_0000_0000);
        rd(12'h284, 2'd2, d);
        check("R6 clear view read", 64'(d), 64'h8001);
        wr(12'h284, 2'd0, 32'h01);
        check("R6 clear-pending", pending_o, 64'h0000_8000_0000_0000);
        @(negedge clk);
        pend_set_i = 64'd1 << 40;
        @(negedge clk);
        pend_set_i = '0;
        check("R6 hw set", pending_o, 64'h0000_8100_0000_0000);
    endtask

    task automatic t_active();
        logic [31:0] d;
        active_i = 64'h1234_0000_0000_0000;
        rd(12'h304, 2'd2, d);
        check("R7 active read", 64'(d), 64'h1234_0000);
        wr(12'h304, 2'd2, 32'hFFFF_FFFF);
        rd(12'h304, 2'd2, d);
        check("R7 write ignored", 64'(d), 64'h1234_0000);
        check("R7 no err", 64'(err_o), 64'd0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(12'h420, 2'd2, 32'h4433_2211);
        check("R8 prio 33", 64'(prio_o[8*33 +: 8]), 64'h22);
        check("R8 prio 35", 64'(prio_o[8*35 +: 8]), 64'h44);
        rd(12'h422, 2'd0, d);
        check("R12 byte read lanes", 64'(d), 64'h33);
        rd(12'h421, 2'd1, d);
        check("R12 half read", 64'(d), 64'h3322);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(12'h43E, 2'd1, 32'hBBAA);
        check("R12 misaligned half 62", 64'(prio_o[8*62 +: 8]), 64'hAA);
        check("R12 misaligned half 63", 64'(prio_o[8*63 +: 8]), 64'hBB);
        rd(12'h43C, 2'd2, d);
        check("R12 word read", 64'(d), 64'hBBAA_0000);
        check("R12 no err", 64'(err_o), 64'd0);
    endtask

    task automatic t_target();
        logic [31:0] d;
        wr(12'h800, 2'd2, 32'hFFFF_FFFF);
        rd(12'h800, 2'd2, d);
        check("R9 low forced", 64'(d), 64'd0);
        wr(12'h81C, 2'd2, 32'hFFFF_FFFF);
        rd(12'h81C, 2'd2, d);
        check("R9 ids 28-31", 64'(d), 64'h0101_0100);
        wr(12'h820, 2'd0, 32'h03);
        rd(12'h820, 2'd0, d);
        check("R9 id 32 set", 64'(d), 64'h01);
        wr(12'h820, 2'd0, 32'h02);
        rd(12'h820, 2'd0, d);
        check("R9 id 32 clear", 64'(d), 64'h00);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr(12'hC08, 2'd0, 32'h08);
        check("R10 id 33 edge", edge_o, 64'h0000_0002_0000_FFFF);
        rd(12'hC08, 2'd0, d);
        check("R10 cfg read", 64'(d), 64'h08);
        wr(12'hC04, 2'd2, 32'h0);
        check("R10 forced edge", edge_o, 64'h0000_0002_FFFF_FFFF);
        rd(12'hC04, 2'd2, d);
        check("R10 odd bits read", 64'(d), 64'hAAAA_AAAA);
        wr(12'hC08, 2'd0, 32'h55);
        check("R10 even bits no edge", edge_o, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_error();
        logic [31:0] d;
        check("R11 err clear before", 64'(err_o), 64'd0);
        rd(12'h108, 2'd2, d);
        check("R11 out-of-range read", 64'(d), 64'd0);
        check("R11 err set", 64'(err_o), 64'd1);
        wr(12'h108, 2'd2, 32'hFFFF_FFFF);
        check("R11 write dropped", enable_o, 64'h0000_00A0_0000_FFFF);
        rd(12'h380, 2'd2, d);
        check("R11 unmapped read", 64'(d), 64'd0);
        rd(12'h000, 2'd0, d);
        check("R11 err sticky", 64'(err_o), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_type();
        t_enable();
        t_pending();
        t_active();
        t_prio();
        t_multi();
        t_target();
        t_config();
        t_error();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule